// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block supplies the word a host sees on the data bus while an internally timed word program or erase is in progress. A one-cycle start pulse begins an operation and carries its kind and the data word being written. For as long as the operation runs, every read returns a status word in place of array data. That status word carries two signatures that let the host detect the end of the operation without any status register.

The first signature is a poll bit. During a program it holds the inverse of bit 7 of the loaded word, and during an erase it is held at zero. The second signature is a toggle bit that changes state on each read. The block counts down a fixed number of clock cycles, which stands in for the array's own timing, and then falls back to passing array read data straight through. Any start pulse that arrives while an operation runs is dropped. The host sees completion as the poll bit matching the true data and the toggle bit standing still.

Top module: `statrep_top`

## Requirements
- R1: After reset no operation is running (`opBusy` = 0) and `busOut` equals `arrayData`.
- R2: While a program operation runs, `busOut[7]` is the inverse of bit 7 of the data word given with its start pulse.
- R3: While an erase operation runs, `busOut[7]` is 0.
- R4: While any operation runs, `busOut[6]` is 0 at the first read. It then flips once for each rising edge of `readStrobe` that the clock samples. Holding the strobe high for several cycles counts as one read.
- R5: A program operation (`startOp` = 0) keeps `opBusy` high for exactly `PROG_CYCLES` clock cycles, beginning with the cycle after its start pulse.
- R6: An erase operation (`startOp` = 1) keeps `opBusy` high for exactly `ERASE_CYCLES` clock cycles, beginning with the cycle after its start pulse.
- R7: A start pulse that arrives while an operation runs is ignored. The running operation keeps its length, its poll bit and its toggle state.
- R8: When no operation runs, `busOut` equals `arrayData` for any value of `readStrobe`, and reads do not disturb the toggle state of later operations.
- R9: Status can be read in the very first cycle after the start pulse. In that cycle `opBusy` is 1 and the status word is already valid.
- R10: While an operation runs, every bit of `busOut` except bits 7 and 6 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to begin an operation |
| startOp | input | 1 | Operation kind: 0 program, 1 erase |
| startData | input | DATA_W | Data word loaded with a program request |
| readStrobe | input | 1 | Host read strobe; each rising edge is one read |
| arrayData | input | DATA_W | Read data from the memory array |
| busOut | output | DATA_W | Data returned to the host |
| opBusy | output | 1 | High while an operation is in progress |

## Verification
The checker covers the following on every cycle:
- `busOut` passes `arrayData` whenever the block is idle.
- The status word keeps all bits other than 7 and 6 at zero.
- The toggle bit holds between read edges.
- A dropped start pulse leaves the poll bit unchanged.
- An accepted start produces busy with a cleared toggle bit.
- Busy never outlasts the longer duration.

Only the bench scenarios can show the rest:
- The exact program and erase durations.
- The poll bit's value for each loaded data word.
- The toggle count over a sequence of reads, including a strobe held high across cycles.
- That idle reads leave the next operation's toggle state unaffected.

// File: rtl/statrep_pkg.sv
`timescale 1ns/100ps
package statrep_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } opKind_e;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;

  typedef struct packed {
    logic load;
    logic flip;
    logic busy;
  } ctrlStrobe_t;
endpackage

// File: rtl/statrep_ctrl.sv
`timescale 1ns/100ps
module statrep_ctrl
  import statrep_pkg::*;
#(
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  opKind_e     startOp,
  input  logic        readStrobe,
  output ctrlStrobe_t strobes
);
  localparam int MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

  logic             busyQ;
  logic [CNT_W-1:0] remainQ;
  logic             rdPrevQ;
  logic             acceptStart;
  logic             readRise;
  logic [CNT_W-1:0] lenSel;

  assign acceptStart = startPulse && !busyQ;
  assign readRise    = readStrobe && !rdPrevQ;
  assign lenSel      = (startOp == OP_ERASE) ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      remainQ <= '0;
      rdPrevQ <= 1'b0;
    end else begin
      rdPrevQ <= readStrobe;
      if (acceptStart) begin
        busyQ   <= 1'b1;
        remainQ <= lenSel;
      end else if (busyQ) begin
        if (remainQ == CNT_W'(1)) begin
          busyQ <= 1'b0;
        end
        remainQ <= remainQ - CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobes.load = acceptStart;
    strobes.flip = busyQ && readRise;
    strobes.busy = busyQ;
  end
endmodule

// File: rtl/statrep_path.sv
`timescale 1ns/100ps
module statrep_path
  import statrep_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  opKind_e           startOp,
  input  logic [DATA_W-1:0] startData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] busOut
);
  logic              pollQ;
  logic              togQ;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollQ <= 1'b0;
      togQ  <= 1'b0;
    end else if (strobes.load) begin
      pollQ <= (startOp == OP_ERASE) ? 1'b0 : ~startData[POLL_BIT];
      togQ  <= 1'b0;
    end else if (strobes.flip) begin
      togQ <= ~togQ;
    end
  end

  always_comb begin
    statusWord             = '0;
    statusWord[POLL_BIT]   = pollQ;
    statusWord[TOGGLE_BIT] = togQ;
    busOut = strobes.busy ? statusWord : arrayData;
  end
endmodule

// File: rtl/statrep_top.sv
`timescale 1ns/100ps
module statrep_top
  import statrep_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              startOp,
  input  logic [DATA_W-1:0] startData,
  input  logic              readStrobe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] busOut,
  output logic              opBusy
);
  ctrlStrobe_t strobes;
  opKind_e     opKind;

  assign opKind = opKind_e'(startOp);

  statrep_ctrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .startOp   (opKind),
    .readStrobe(readStrobe),
    .strobes   (strobes)
  );

  statrep_path #(
    .DATA_W(DATA_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .startOp  (opKind),
    .startData(startData),
    .arrayData(arrayData),
    .busOut   (busOut)
  );

  assign opBusy = strobes.busy;
endmodule

// File: rtl/statrep_chk.sv
`timescale 1ns/100ps
module statrep_chk #(
  parameter int DATA_W       = 16,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              readStrobe,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] busOut,
  input logic              opBusy
);
  localparam int MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int RUN_W      = $clog2(MAX_CYCLES + 1) + 1;
  localparam logic [DATA_W-1:0] ZERO_MASK = ~((DATA_W'(1) << 7) | (DATA_W'(1) << 6));

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN || !opBusy) busyRun <= '0;
    else                  busyRun <= busyRun + RUN_W'(1);
  end

  // R8
  idle_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opBusy |-> busOut == arrayData);

  // R10
  status_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    opBusy |-> (busOut & ZERO_MASK) == '0);

  // R4
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opBusy && !(readStrobe && !$past(readStrobe))) |=> (!opBusy || $stable(busOut[6])));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !opBusy) |=> (opBusy && !busOut[6]));

  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opBusy && startPulse) |=> (!opBusy || $stable(busOut[7])));

  // R5 R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    opBusy |-> busyRun < RUN_W'(MAX_CYCLES));
endmodule

bind statrep_top statrep_chk #(
  .DATA_W      (DATA_W),
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .readStrobe(readStrobe),
  .arrayData (arrayData),
  .busOut    (busOut),
  .opBusy    (opBusy)
);

// File: tb/statrep_top_test.sv
`timescale 1ns/100ps
module statrep_top_test;
  localparam int DATA_W       = 16;
  localparam int PROG_CYCLES  = 6;
  localparam int ERASE_CYCLES = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic              startOp = 1'b0;
  logic [DATA_W-1:0] startData = '0;
  logic              readStrobe = 1'b0;
  logic [DATA_W-1:0] arrayData = 16'hC3A5;
  logic [DATA_W-1:0] busOut;
  logic              opBusy;

  statrep_top #(
    .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startOp(startOp),
    .startData(startData), .readStrobe(readStrobe), .arrayData(arrayData),
    .busOut(busOut), .opBusy(opBusy)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [DATA_W-1:0] val;
    logic              b;
    string             tag;
  } item_t;
  item_t sb[$];

  int                startCyc = -1000;
  int                opLen = 0;
  int                nRise = 0;
  bit                curErase = 1'b0;
  logic [DATA_W-1:0] curData = '0;
  bit                seenHigh = 1'b0;

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit expBusy();
    return (cyc >= startCyc) && (cyc < startCyc + opLen);
  endfunction

  task automatic pushRead(input string tag);
    item_t it;
    it.tag = tag;
    it.b   = expBusy();
    if (it.b) begin
      it.val    = '0;
      it.val[7] = curErase ? 1'b0 : ~curData[7];
      it.val[6] = nRise[0];
      nRise++;
    end else begin
      it.val = arrayData;
    end
    sb.push_back(it);
  endtask

  task automatic readPulse(input string tag, input int hold);
    @(negedge clk); #1;
    readStrobe = 1'b1;
    pushRead(tag);
    repeat (hold) @(negedge clk);
    #1 readStrobe = 1'b0;
  endtask

  task automatic startOpTask(input bit erase, input logic [DATA_W-1:0] data);
    bit wasBusy;
    @(negedge clk); #1;
    startPulse = 1'b1;
    startOp    = erase;
    startData  = data;
    wasBusy    = expBusy();
    @(posedge clk); #1;
    startPulse = 1'b0;
    if (!wasBusy) begin
      startCyc = cyc;
      opLen    = erase ? ERASE_CYCLES : PROG_CYCLES;
      curErase = erase;
      curData  = data;
      nRise    = 0;
    end
  endtask

  task automatic busyScan(input string tag);
    for (int k = 0; k < opLen + 2; k++) begin
      @(negedge clk); #2;
      chk(tag, DATA_W'(opBusy), DATA_W'(expBusy()));
    end
  endtask

  task automatic waitIdle();
    while (expBusy()) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (readStrobe && !seenHigh && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk({it.tag, " busy"}, DATA_W'(opBusy), DATA_W'(it.b));
      chk({it.tag, " data"}, busOut, it.val);
    end
    seenHigh = readStrobe;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset busy", DATA_W'(opBusy), '0);
    chk("R1 reset passthru", busOut, arrayData);
    @(negedge clk); #1 rstN = 1'b1;

    // R2 with loaded bit 7 set, R9 immediate read, R4 toggling
    startOpTask(1'b0, 16'h00F0);
    readPulse("R9 first read", 1);
    readPulse("R2 R4 read2", 1);
    readPulse("R2 R4 read3", 1);
    waitIdle();
    readPulse("R8 after program", 1);

    // R2 with loaded bit 7 clear
    startOpTask(1'b0, 16'h1234);
    readPulse("R2 R10 read1", 1);
    readPulse("R2 R4 read2", 1);
    waitIdle();

    // R5 exact program length
    startOpTask(1'b0, 16'h5A5A);
    busyScan("R5 busy window");
    // R6 exact erase length
    startOpTask(1'b1, 16'hFFFF);
    busyScan("R6 busy window");

    // R3, R4 held strobe, R7 ignored start
    startOpTask(1'b1, 16'h0000);
    readPulse("R3 R9 read1", 1);
    readPulse("R4 held read", 3);
    readPulse("R4 after hold", 1);
    startOpTask(1'b0, 16'h0000);
    readPulse("R7 after ignored start", 1);
    readPulse("R7 R4 read", 1);
    waitIdle();

    // R8 idle reads with several array patterns
    arrayData = 16'h0F0F;
    readPulse("R8 idle read a", 1);
    arrayData = 16'hFFC0;
    readPulse("R8 idle read b", 2);
    arrayData = 16'h0040;
    readPulse("R8 idle read c", 1);
    startOpTask(1'b0, 16'h0080);
    readPulse("R8 toggle fresh after idle reads", 1);
    readPulse("R2 R4 read2 after idle", 1);
    waitIdle();
    readPulse("R8 final idle", 1);

    repeat (3) @(negedge clk);
    if (sb.size() != 0) chk("scoreboard drained", DATA_W'(sb.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule